// File: doc/BRIEF.md
# Multiframe Alignment Proving Monitor

This block watches one receive channel of a framed serial line that carries signaling in plain bit-oriented form. It takes the bit clock, the serial data, a pulse that marks the first bit of each multiframe, and a red-alarm input that reports loss of alignment. Received bits reach the write side only after the multiframe structure has been proven stable over several consecutive multiframes. No HDLC deformatting is applied: every bit leaves exactly as it arrived.

Proving runs in three stages. The first stage ends at the first multiframe pulse seen with the alarm low, so it lasts at most one multiframe on an aligned line. The second and third stages each need the next pulse to arrive exactly one full multiframe after the previous one. A pulse that arrives early restarts the count from that pulse. A missing pulse, or a high alarm at any point, returns the monitor to the first stage. Once proven, the channel stays synchronized, whatever the pulses do, until the alarm goes high. That drop is reported once as a loss-of-alignment event on the status path.

The multiframe length is `FRAMES * FRAME_BITS` bits. With the defaults this is 12 frames of 193 bits. The number of proving stages is `PROVE_PERIODS`.

Top module: `mf_align_monitor`

## Requirements
- R1: After reset, `synced_o`, `wr_en_o` and `los_o` are 0. An asynchronous reset while synchronized clears `synced_o` without raising `los_o`.
- R2: Proving stage one ends on the first clock edge with `mf_sync_i`=1 and `red_i`=0. `synced_o` rises after the edge that samples the third such pulse, provided each of the last two pulses came exactly MF_LEN bit clocks after the one before it.
- R3: A pulse that arrives fewer than MF_LEN clocks after the previous accepted pulse does not fail proving. It restarts the full-multiframe stages, counting from that pulse.
- R4: If no pulse is sampled at the edge MF_LEN clocks after the previous accepted pulse, proving returns to stage one.
- R5: `red_i`=1 on any edge during proving returns the monitor to stage one and discards any pulse sampled on that edge. While `red_i` stays high, `synced_o` never rises.
- R6: Once synchronized, the monitor stays synchronized whether pulses arrive early, late or not at all, for as long as `red_i` is 0.
- R7: While synchronized, `red_i`=1 at an edge clears `synced_o` after that edge.
- R8: `los_o` is high for exactly one cycle, in the cycle after the edge at which `synced_o` goes from 1 to 0. It is never high at any other time.
- R9: `wr_en_o` equals `synced_o`. Whenever `wr_en_o` is 1, `data_o` holds the `ser_i` value sampled at the same edge, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_i | input | 1 | Received serial data bit |
| mf_sync_i | input | 1 | High during the first bit of a multiframe |
| red_i | input | 1 | Red alarm: loss of alignment reported upstream |
| synced_o | output | 1 | Multiframe alignment proven |
| wr_en_o | output | 1 | Write enable for `data_o` |
| data_o | output | 1 | Received bit passed through, one clock late |
| los_o | output | 1 | Single-cycle loss-of-alignment event |

## Verification
On every cycle, the assertions check these properties: the loss event fires exactly on a drop of `synced_o` and lasts one cycle; a locked channel holds lock while the alarm is low and drops it when the alarm is high; lock is only gained on an alarm-free pulse; and written data equals the bit sampled one edge earlier. Three things need the bench's scenarios: the exact number of on-time pulses needed to lock, an early pulse restarting the count, and a missing pulse sending proving back to stage one. Each of these depends on a sequence spanning several multiframes.

// File: rtl/mf_align_pkg.sv
package mf_align_pkg;
  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_PROVE = 2'd1,
    ST_LOCK  = 2'd2
  } align_state_e;
endpackage

// File: rtl/mf_bit_counter.sv
module mf_bit_counter #(
  parameter int unsigned MF_LEN = 2316
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic due_o
);
  localparam int unsigned CW = (MF_LEN > 2) ? $clog2(MF_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(MF_LEN - 1);

  logic [CW-1:0] cnt_q;

  // saturates at LAST; cleared on every accepted pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign due_o = (cnt_q == LAST);
endmodule

// File: rtl/mf_prove_fsm.sv
module mf_prove_fsm
  import mf_align_pkg::*;
#(
  parameter int unsigned PROVE_PERIODS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic red_i,
  input  logic due_i,
  output logic cnt_clr_o,
  output logic lock_d_o,
  output logic synced_o,
  output logic los_o
);
  localparam int unsigned FULL = PROVE_PERIODS - 1;  // full-length stages
  localparam int unsigned PW   = (PROVE_PERIODS > 2) ? $clog2(PROVE_PERIODS) : 1;
  localparam logic [PW-1:0] PER_LAST = PW'(FULL - 1);

  align_state_e state_q, state_d;
  logic [PW-1:0] per_q, per_d;
  logic          los_q;

  always_comb begin
    state_d   = state_q;
    per_d     = per_q;
    cnt_clr_o = 1'b0;
    unique case (state_q)
      ST_HUNT: begin
        if (!red_i && sync_i) begin
          state_d   = ST_PROVE;
          per_d     = '0;
          cnt_clr_o = 1'b1;
        end
      end
      ST_PROVE: begin
        if (red_i) begin
          state_d   = ST_HUNT;
          per_d     = '0;
          cnt_clr_o = 1'b1;
        end else if (sync_i) begin
          cnt_clr_o = 1'b1;
          if (!due_i)                 per_d   = '0;  // early: restart from here
          else if (per_q == PER_LAST) state_d = ST_LOCK;
          else                        per_d   = per_q + 1'b1;
        end else if (due_i) begin
          state_d = ST_HUNT;                         // pulse missing
          per_d   = '0;
        end
      end
      ST_LOCK: begin
        if (red_i) begin
          state_d   = ST_HUNT;
          per_d     = '0;
          cnt_clr_o = 1'b1;
        end
      end
      default: begin
        state_d = ST_HUNT;
        per_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      per_q   <= '0;
      los_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      per_q   <= per_d;
      los_q   <= (state_q == ST_LOCK) && (state_d != ST_LOCK);
    end
  end

  assign lock_d_o = (state_d == ST_LOCK);
  assign synced_o = (state_q == ST_LOCK);
  assign los_o    = los_q;
endmodule

// File: rtl/mf_data_gate.sv
module mf_data_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ser_i,
  input  logic lock_d_i,
  output logic data_o,
  output logic wr_en_o
);
  logic data_q, wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= 1'b0;
      wr_q   <= 1'b0;
    end else begin
      data_q <= ser_i;
      wr_q   <= lock_d_i;
    end
  end

  assign data_o  = data_q;
  assign wr_en_o = wr_q;
endmodule

// File: rtl/mf_align_monitor.sv
module mf_align_monitor #(
  parameter int unsigned FRAMES        = 12,
  parameter int unsigned FRAME_BITS    = 193,
  parameter int unsigned PROVE_PERIODS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ser_i,
  input  logic mf_sync_i,
  input  logic red_i,
  output logic synced_o,
  output logic wr_en_o,
  output logic data_o,
  output logic los_o
);
  localparam int unsigned MF_LEN = FRAMES * FRAME_BITS;

  logic due, cnt_clr, lock_d;

  mf_bit_counter #(.MF_LEN(MF_LEN)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .due_o  (due)
  );

  mf_prove_fsm #(.PROVE_PERIODS(PROVE_PERIODS)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_i    (mf_sync_i),
    .red_i     (red_i),
    .due_i     (due),
    .cnt_clr_o (cnt_clr),
    .lock_d_o  (lock_d),
    .synced_o  (synced_o),
    .los_o     (los_o)
  );

  mf_data_gate u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ser_i    (ser_i),
    .lock_d_i (lock_d),
    .data_o   (data_o),
    .wr_en_o  (wr_en_o)
  );
endmodule

// File: rtl/mf_align_monitor_chk.sv
module mf_align_monitor_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ser_i,
  input logic mf_sync_i,
  input logic red_i,
  input logic synced_o,
  input logic wr_en_o,
  input logic data_o,
  input logic los_o
);
  p_los_on_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    los_o |-> (!synced_o && $past(synced_o)));
  p_drop_reported_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(synced_o) |-> los_o);
  p_los_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    los_o |=> !los_o);
  p_red_unlocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (synced_o && red_i) |=> !synced_o);
  p_lock_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (synced_o && !red_i) |=> synced_o);
  p_lock_needs_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(synced_o) |-> ($past(mf_sync_i) && !$past(red_i)));
  p_wr_matches_sync_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o == synced_o);
  p_data_pass_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (data_o == $past(ser_i)));
endmodule

bind mf_align_monitor mf_align_monitor_chk u_chk (.*);

// File: tb/mf_align_monitor_tb.sv
`timescale 1ns/1ps
module mf_align_monitor_tb;
  localparam int unsigned FRAMES = 2, FRAME_BITS = 8;
  localparam int unsigned MF_LEN = FRAMES * FRAME_BITS;  // 16
  localparam int unsigned NV = 20;

  // {gap[7:0], sync, red, exp_synced, exp_los}: gap idle cycles, then one event cycle
  localparam logic [11:0] VEC [NV] = '{
    {8'd3,  4'b1000},  // stage one ends (R2)
    {8'd15, 4'b1000},  // stage two on time (R2)
    {8'd15, 4'b1010},  // stage three on time -> lock (R2)
    {8'd5,  4'b1010},  // stray pulse while locked ignored (R6)
    {8'd2,  4'b0101},  // alarm drops lock, one event (R7, R8)
    {8'd0,  4'b0100},  // alarm again: no second event (R8)
    {8'd4,  4'b1000},  // stage one
    {8'd15, 4'b1100},  // on-time pulse with alarm aborts (R5)
    {8'd2,  4'b1000},  // stage one again
    {8'd10, 4'b1000},  // early pulse restarts counting (R3)
    {8'd15, 4'b1000},  // stage two from the early pulse (R3)
    {8'd15, 4'b1010},  // lock (R3)
    {8'd3,  4'b0101},  // alarm drop (R7, R8)
    {8'd0,  4'b1000},  // stage one
    {8'd15, 4'b1000},  // stage two
    {8'd20, 4'b0000},  // pulse missing (R4)
    {8'd15, 4'b1000},  // treated as stage one (R4)
    {8'd15, 4'b1000},  // stage two
    {8'd15, 4'b1010},  // lock
    {8'd40, 4'b0010}   // no pulses at all, lock held (R6)
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic ser_i = 1'b0, mf_sync_i = 1'b0, red_i = 1'b0;
  logic synced_o, wr_en_o, data_o, los_o;
  int total = 0, bad = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic last_ser;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  mf_align_monitor #(.FRAMES(FRAMES), .FRAME_BITS(FRAME_BITS), .PROVE_PERIODS(3)) u_dut (
    .clk_i, .rst_ni, .ser_i, .mf_sync_i, .red_i,
    .synced_o, .wr_en_o, .data_o, .los_o
  );

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // one bit clock: drive at negedge, results visible at the next negedge
  task automatic cyc(input logic s, input logic r);
    mf_sync_i = s;
    red_i     = r;
    ser_i     = lfsr[0];
    last_ser  = lfsr[0];
    lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    @(negedge clk_i);
  endtask

  task automatic chk_out(input logic es, input logic el, input string req);
    chk(synced_o, es, req, "synced_o");
    chk(wr_en_o, es, "R9", "wr_en_o");
    chk(los_o, el, req, "los_o");
    if (es) chk(data_o, last_ser, "R9", "data_o");
  endtask

  initial begin
    #(20ns * 100000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic prev;
    repeat (3) @(negedge clk_i);
    chk(synced_o, 1'b0, "R1", "reset synced_o");
    chk(wr_en_o, 1'b0, "R1", "reset wr_en_o");
    chk(los_o, 1'b0, "R1", "reset los_o");
    rst_ni = 1'b1;
    cyc(1'b0, 1'b0);
    chk_out(1'b0, 1'b0, "R1");

    prev = 1'b0;
    for (int i = 0; i < NV; i++) begin
      for (int g = 0; g < int'(VEC[i][11:4]); g++) begin
        cyc(1'b0, 1'b0);
        chk_out(prev, 1'b0, "R6");
      end
      cyc(VEC[i][3], VEC[i][2]);
      chk_out(VEC[i][1], VEC[i][0], $sformatf("R2-vec%0d", i));
      prev = VEC[i][1];
    end

    // async reset while locked: no event (R1)
    rst_ni = 1'b0;
    #1;
    chk(synced_o, 1'b0, "R1", "async clear synced_o");
    @(negedge clk_i);
    chk(los_o, 1'b0, "R1", "no event on reset");
    rst_ni = 1'b1;
    cyc(1'b0, 1'b0);
    chk_out(1'b0, 1'b0, "R1");

    // alarm held across three well-spaced pulses: never locks (R5)
    cyc(1'b1, 1'b1);
    for (int k = 0; k < 2; k++) begin
      for (int g = 0; g < int'(MF_LEN) - 1; g++) cyc(1'b0, 1'b1);
      cyc(1'b1, 1'b1);
      chk_out(1'b0, 1'b0, "R5");
    end
    // same pattern without alarm locks on the third pulse (R2)
    cyc(1'b1, 1'b0);
    chk_out(1'b0, 1'b0, "R2");
    for (int g = 0; g < int'(MF_LEN) - 1; g++) cyc(1'b0, 1'b0);
    cyc(1'b1, 1'b0);
    chk_out(1'b0, 1'b0, "R2");
    for (int g = 0; g < int'(MF_LEN) - 1; g++) cyc(1'b0, 1'b0);
    cyc(1'b1, 1'b0);
    chk_out(1'b1, 1'b0, "R2");
    cyc(1'b0, 1'b1);
    chk_out(1'b0, 1'b1, "R7");
    cyc(1'b0, 1'b0);
    chk_out(1'b0, 1'b0, "R8");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule